// File: doc/BRIEF.md
# USB Suspend and Resume Signaling Sequencer

This block sequences the suspend and resume handshake of a low-speed or full-speed USB port on a transceiver driven over a 4-bit link. It runs on the 60 MHz link clock. It watches the received line state and drives the operating-mode code, the active-low suspend control, the stop strobe and the line symbol the transceiver should transmit. It acts as a host or as a peripheral. The port counts as a host only when both the D+ and D- pull-down enables are set.

As a peripheral, the block counts consecutive idle J cycles on the line. When the bus has been quiet for the programmed time (3 ms on silicon), it pulls the suspend control low. A K seen while suspended produces a one-cycle stop strobe and powers the transceiver again. The block then returns to normal operation once the closing SE0 followed by J has been observed. As a host, a resume request switches the operating mode to raw drive and transmits K for the programmed resume time (20 ms on silicon). It then pulses the stop strobe and appends an end-of-packet of two low-speed bit times of SE0 and one of J. Finally it restores normal mode.

All durations are parameters counted in clock cycles, so a bench can shorten them.

Top module: `usb_susp_seq`

## Requirements
- R1: In peripheral role (either pull-down enable low), IDLE_CYC consecutive cycles of line state J (2'b01) in normal idle drive suspend_n to 0 from the cycle after the last of them. While suspended, opmode stays 2'b00 and tx_en stays 0.
- R2: Any line state other than J during idle detection restarts the count, so a J run shorter than IDLE_CYC never suspends. In host role the port never suspends.
- R3: In host role, a resume_req sampled in idle sets opmode to 2'b10. It then drives tx_en=1 with tx_sym K (2'b10) for exactly RESUME_CYC cycles, followed by one cycle in which stp=1 and K is still driven. Line symbol codes are 2'b00 SE0, 2'b01 J and 2'b10 K.
- R4: A suspended peripheral that samples K (2'b10) drives stp=1 for exactly one cycle on the next cycle, with suspend_n back at 1.
- R5: After the host stop strobe, tx_sym is SE0 (2'b00) for 2*LS_BIT_CYC cycles, then J (2'b01) for LS_BIT_CYC cycles, with tx_en=1 and opmode 2'b10 throughout.
- R6: The host sequence starts only when both pd_dp_en and pd_dm_en are 1. Otherwise resume_req is ignored and tx_en stays 0.
- R7: When the end-of-packet is complete, opmode returns to 2'b00 and tx_en to 0. tx_sym reads J whenever tx_en is 0.
- R8: A woken peripheral does not restart idle detection until it has sampled SE0 and then J. After that, a new full idle run suspends it again.
- R9: A synchronous reset returns the block to idle: opmode 2'b00, suspend_n=1, stp=0 and tx_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock (60 MHz on silicon) |
| rst | input | 1 | Synchronous reset, active high |
| linestate | input | 2 | Received line state: 00 SE0, 01 J, 10 K |
| pd_dp_en | input | 1 | D+ pull-down enabled |
| pd_dm_en | input | 1 | D- pull-down enabled; both set selects host role |
| resume_req | input | 1 | Host request to start resume signaling |
| opmode | output | 2 | Operating mode code: 00 normal, 10 raw drive |
| suspend_n | output | 1 | Transceiver suspend control, low = low-power |
| stp | output | 1 | One-cycle stop strobe |
| tx_en | output | 1 | Line symbol drive active |
| tx_sym | output | 2 | Symbol to drive: 00 SE0, 01 J, 10 K |

## Verification
The checker assumes that reset is applied synchronously from the first edge. It also assumes that the line state is already synchronized to the clock, so a K seen during suspend is a real wake event. No assertion depends on the role inputs staying fixed. The only role check is that a drive burst begins when both pull-downs are set, which holds because role is sampled once, in idle. The stimulus therefore toggles the pull-down enables and resume_req freely. It draws line states in runs of random length, including the unused code 2'b11, which the block treats as non-idle.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SUSP,
      ST_WAKE,
      ST_PWAIT,
      ST_PEOP,
      ST_HRES,
      ST_HSTP,
      ST_HSE0,
      ST_HJ
   } seq_st_t;

   localparam logic [1:0] LS_SE0 = 2'b00;
   localparam logic [1:0] LS_J   = 2'b01;
   localparam logic [1:0] LS_K   = 2'b10;

   localparam logic [1:0] OPM_NORM = 2'b00;
   localparam logic [1:0] OPM_RAW  = 2'b10;

endpackage

// File: rtl/usb_idle_detect.sv
module usb_idle_detect #(
   parameter int IDLE_CYC = 180000
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       en,
   input  logic [1:0] linestate,
   output logic       hit
);
   import usb_susp_pkg::*;

   logic is_j;
   assign is_j = en && (linestate == LS_J);

   generate
      if (IDLE_CYC == 1) begin : g_direct
         assign hit = is_j;
      end else begin : g_count
         localparam int CW = $clog2(IDLE_CYC);
         logic [CW-1:0] run_q;

         assign hit = is_j && (run_q == CW'(IDLE_CYC - 1));

         always_ff @(posedge clk) begin
            if (rst || !is_j || hit) begin
               run_q <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/usb_dur_timer.sv
module usb_dur_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);
   logic [TW-1:0] left_q;

   assign expired = (left_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         left_q <= '0;
      end else if (load) begin
         left_q <= load_val;
      end else if (!expired) begin
         left_q <= left_q - 1'b1;
      end
   end

endmodule

// File: rtl/usb_susp_out.sv
module usb_susp_out
   import usb_susp_pkg::*;
(
   input  seq_st_t    st,
   output logic [1:0] opmode,
   output logic       suspend_n,
   output logic       stp,
   output logic       tx_en,
   output logic [1:0] tx_sym
);
   always_comb begin
      opmode    = OPM_NORM;
      suspend_n = 1'b1;
      stp       = 1'b0;
      tx_en     = 1'b0;
      tx_sym    = LS_J;
      unique case (st)
         ST_SUSP:  suspend_n = 1'b0;
         ST_WAKE:  stp = 1'b1;
         ST_HRES: begin
            opmode = OPM_RAW;
            tx_en  = 1'b1;
            tx_sym = LS_K;
         end
         ST_HSTP: begin
            opmode = OPM_RAW;
            tx_en  = 1'b1;
            tx_sym = LS_K;
            stp    = 1'b1;
         end
         ST_HSE0: begin
            opmode = OPM_RAW;
            tx_en  = 1'b1;
            tx_sym = LS_SE0;
         end
         ST_HJ: begin
            opmode = OPM_RAW;
            tx_en  = 1'b1;
            tx_sym = LS_J;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/usb_susp_seq.sv
module usb_susp_seq #(
   parameter int IDLE_CYC   = 180000,
   parameter int RESUME_CYC = 1200000,
   parameter int LS_BIT_CYC = 40
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] linestate,
   input  logic       pd_dp_en,
   input  logic       pd_dm_en,
   input  logic       resume_req,
   output logic [1:0] opmode,
   output logic       suspend_n,
   output logic       stp,
   output logic       tx_en,
   output logic [1:0] tx_sym
);
   import usb_susp_pkg::*;

   localparam int SE0_CYC = 2 * LS_BIT_CYC;
   localparam int MAX_DUR = (RESUME_CYC > SE0_CYC) ? RESUME_CYC : SE0_CYC;
   localparam int TW      = $clog2(MAX_DUR + 1);

   generate
      if (IDLE_CYC < 1) begin : g_bad_idle
         $error("IDLE_CYC must be at least 1");
      end
      if (RESUME_CYC < 1) begin : g_bad_res
         $error("RESUME_CYC must be at least 1");
      end
      if (LS_BIT_CYC < 1) begin : g_bad_bit
         $error("LS_BIT_CYC must be at least 1");
      end
   endgenerate

   seq_st_t       st_q, st_d;
   logic          host_role;
   logic          idle_en, idle_hit;
   logic          t_load, t_done;
   logic [TW-1:0] t_val;

   assign host_role = pd_dp_en && pd_dm_en;
   assign idle_en   = (st_q == ST_IDLE) && !host_role;

   usb_idle_detect #(.IDLE_CYC(IDLE_CYC)) u_idle (
      .clk       (clk),
      .rst       (rst),
      .en        (idle_en),
      .linestate (linestate),
      .hit       (idle_hit)
   );

   usb_dur_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_done)
   );

   always_comb begin
      st_d   = st_q;
      t_load = 1'b0;
      t_val  = '0;
      unique case (st_q)
         ST_IDLE: begin
            if (host_role && resume_req) begin
               st_d   = ST_HRES;
               t_load = 1'b1;
               t_val  = TW'(RESUME_CYC - 1);
            end else if (idle_hit) begin
               st_d = ST_SUSP;
            end
         end
         ST_SUSP:  if (linestate == LS_K) st_d = ST_WAKE;
         ST_WAKE:  st_d = ST_PWAIT;
         ST_PWAIT: if (linestate == LS_SE0) st_d = ST_PEOP;
         ST_PEOP:  if (linestate == LS_J) st_d = ST_IDLE;
         ST_HRES:  if (t_done) st_d = ST_HSTP;
         ST_HSTP: begin
            st_d   = ST_HSE0;
            t_load = 1'b1;
            t_val  = TW'(SE0_CYC - 1);
         end
         ST_HSE0: begin
            if (t_done) begin
               st_d   = ST_HJ;
               t_load = 1'b1;
               t_val  = TW'(LS_BIT_CYC - 1);
            end
         end
         ST_HJ:    if (t_done) st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_IDLE;
      else     st_q <= st_d;
   end

   usb_susp_out u_out (
      .st        (st_q),
      .opmode    (opmode),
      .suspend_n (suspend_n),
      .stp       (stp),
      .tx_en     (tx_en),
      .tx_sym    (tx_sym)
   );

endmodule

// File: rtl/usb_susp_seq_chk.sv
module usb_susp_seq_chk #(
   parameter int RESUME_CYC = 1200000
) (
   input logic       clk,
   input logic       rst,
   input logic [1:0] linestate,
   input logic       pd_dp_en,
   input logic       pd_dm_en,
   input logic [1:0] opmode,
   input logic       suspend_n,
   input logic       stp,
   input logic       tx_en,
   input logic [1:0] tx_sym
);
   localparam int KW = $clog2(RESUME_CYC + 2) + 1;

   logic [KW-1:0] k_run;
   logic          drv_k, drv_se0;

   assign drv_k   = tx_en && (tx_sym == 2'b10);
   assign drv_se0 = tx_en && (tx_sym == 2'b00);

   always_ff @(posedge clk) begin
      if (rst || !drv_k)       k_run <= '0;
      else if (k_run != '1)    k_run <= k_run + 1'b1;
   end

   a_r9_reset_state: assert property (@(posedge clk)
      rst |=> (opmode == 2'b00 && suspend_n && !stp && !tx_en));

   a_r1_quiet_suspend: assert property (@(posedge clk) disable iff (rst)
      !suspend_n |-> (opmode == 2'b00 && !tx_en && !stp));

   a_r4_wake_on_k: assert property (@(posedge clk) disable iff (rst)
      (!suspend_n && linestate == 2'b10) |=> (stp && suspend_n));

   a_r4_stp_single: assert property (@(posedge clk) disable iff (rst)
      stp |=> !stp);

   a_r3_resume_len: assert property (@(posedge clk) disable iff (rst)
      (drv_se0 && $past(drv_k)) |-> (k_run >= KW'(RESUME_CYC)));

   a_r5_stp_before_eop: assert property (@(posedge clk) disable iff (rst)
      (drv_se0 && !$past(drv_se0)) |-> $past(stp));

   a_r3_raw_mode: assert property (@(posedge clk) disable iff (rst)
      tx_en |-> (opmode == 2'b10));

   a_r6_host_entry: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_en) |-> ($past(pd_dp_en) && $past(pd_dm_en)));

   a_r7_back_to_normal: assert property (@(posedge clk) disable iff (rst)
      $fell(tx_en) |-> (opmode == 2'b00 && $past(tx_sym) == 2'b01));

endmodule

bind usb_susp_seq usb_susp_seq_chk #(.RESUME_CYC(RESUME_CYC)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .linestate (linestate),
   .pd_dp_en  (pd_dp_en),
   .pd_dm_en  (pd_dm_en),
   .opmode    (opmode),
   .suspend_n (suspend_n),
   .stp       (stp),
   .tx_en     (tx_en),
   .tx_sym    (tx_sym)
);

// File: tb/usb_susp_seq_tb.sv
module usb_susp_seq_tb;
   localparam int IDLE = 40;
   localparam int RES  = 60;
   localparam int LSB  = 5;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] linestate = 2'b01;
   logic       pd_dp_en = 1'b0, pd_dm_en = 1'b0, resume_req = 1'b0;
   logic [1:0] opmode, tx_sym;
   logic       suspend_n, stp, tx_en;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   usb_susp_seq #(.IDLE_CYC(IDLE), .RESUME_CYC(RES), .LS_BIT_CYC(LSB)) u_dut (
      .clk(clk), .rst(rst), .linestate(linestate), .pd_dp_en(pd_dp_en),
      .pd_dm_en(pd_dm_en), .resume_req(resume_req), .opmode(opmode),
      .suspend_n(suspend_n), .stp(stp), .tx_en(tx_en), .tx_sym(tx_sym));

   // reference model: 0 idle,1 susp,2 wake,3 await SE0,4 await J,5 K,6 stop,7 SE0,8 J
   int m_st = 0, m_run = 0, m_ph = 0;

   always @(posedge clk) begin
      if (rst) begin
         m_st = 0; m_run = 0; m_ph = 0;
      end else begin
         case (m_st)
            0: begin
               if (pd_dp_en && pd_dm_en) begin
                  m_run = 0;
                  if (resume_req) begin m_st = 5; m_ph = 0; end
               end else if (linestate == 2'b01) begin
                  if (m_run + 1 == IDLE) begin m_st = 1; m_run = 0; end
                  else m_run = m_run + 1;
               end else m_run = 0;
            end
            1: if (linestate == 2'b10) m_st = 2;
            2: m_st = 3;
            3: if (linestate == 2'b00) m_st = 4;
            4: if (linestate == 2'b01) m_st = 0;
            5: begin m_ph = m_ph + 1; if (m_ph == RES) begin m_st = 6; m_ph = 0; end end
            6: m_st = 7;
            7: begin m_ph = m_ph + 1; if (m_ph == 2*LSB) begin m_st = 8; m_ph = 0; end end
            8: begin m_ph = m_ph + 1; if (m_ph == LSB) begin m_st = 0; m_ph = 0; end end
            default: m_st = 0;
         endcase
      end
   end

   function automatic string tag_of(int s);
      case (s)
         1: return "R1";
         2: return "R4";
         3, 4: return "R8";
         5, 6: return "R3";
         7, 8: return "R5";
         default: return "R7";
      endcase
   endfunction

   task automatic cmp(string tag, string name, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d (t=%0t)", tag, name, got, exp, $time);
      end
   endtask

   // waits one cycle, then compares all outputs against the model
   task automatic cyc(string tag);
      string t;
      int host_drv;
      @(negedge clk);
      t = (tag == "") ? tag_of(m_st) : tag;
      host_drv = (m_st >= 5) ? 1 : 0;
      cmp(t, "opmode", opmode, host_drv ? 2 : 0);
      cmp(t, "suspend_n", suspend_n, (m_st == 1) ? 0 : 1);
      cmp(t, "stp", stp, (m_st == 2 || m_st == 6) ? 1 : 0);
      cmp(t, "tx_en", tx_en, host_drv);
      cmp(t, "tx_sym", tx_sym, (m_st == 5 || m_st == 6) ? 2 : (m_st == 7) ? 0 : 1);
   endtask

   task automatic hold(logic [1:0] ls, int n, string tag);
      linestate = ls;
      for (int i = 0; i < n; i++) cyc(tag);
   endtask

   initial begin
      repeat (3) cyc("R9");
      rst = 1'b0;
      // R2: interrupted J runs never suspend
      hold(2'b01, IDLE - 1, "R2");
      hold(2'b00, 1, "R2");
      hold(2'b01, IDLE - 1, "R2");
      hold(2'b11, 1, "R2");
      // R1: full idle run suspends
      hold(2'b01, IDLE + 10, "R1");
      // R4: wake on K
      hold(2'b10, 3, "R4");
      // R8: no re-suspend until SE0 then J
      hold(2'b01, IDLE + 20, "R8");
      hold(2'b00, 2, "R8");
      hold(2'b01, IDLE + 5, "R8");
      hold(2'b10, 2, "R4");
      hold(2'b00, 2, "R8");
      hold(2'b01, 3, "R8");
      // R6: single pull-down never starts the host sequence
      pd_dp_en = 1'b1; resume_req = 1'b1;
      hold(2'b01, 10, "R6");
      pd_dp_en = 1'b0; pd_dm_en = 1'b1;
      hold(2'b01, 10, "R6");
      resume_req = 1'b0; pd_dm_en = 1'b0;
      hold(2'b10, 2, "R6");
      // R2: host role never suspends
      pd_dp_en = 1'b1; pd_dm_en = 1'b1;
      hold(2'b01, IDLE + 20, "R2");
      // R3/R5/R7: full host resume
      resume_req = 1'b1; cyc(""); resume_req = 1'b0;
      for (int i = 0; i < RES + 3*LSB + 10; i++) cyc("");
      // R9: reset mid-sequence
      resume_req = 1'b1; cyc("R3"); resume_req = 1'b0;
      hold(2'b01, 20, "R3");
      rst = 1'b1; cyc("R9"); cyc("R9"); rst = 1'b0;
      hold(2'b01, 5, "R9");
      // random mix
      pd_dp_en = 1'b0; pd_dm_en = 1'b0;
      void'($urandom(32'h5a17));
      for (int s = 0; s < 300; s++) begin
         int r = $urandom % 10;
         linestate = (r < 6) ? 2'b01 : (r < 8) ? 2'b10 : (r < 9) ? 2'b00 : 2'b11;
         if ($urandom % 8 == 0) begin
            pd_dp_en = $urandom % 2; pd_dm_en = $urandom % 2;
         end
         resume_req = ($urandom % 6 == 0);
         for (int i = 0, n = 1 + $urandom % ((r < 6) ? 60 : 6); i < n; i++) cyc("");
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule